// File: doc/BRIEF.md
# Power Amplifier Ramp and Amplitude Shaper

This block picks, on every clock, the 8-bit drive code handed to a transmit power amplifier. The codes live in a small table of eight power settings that software fills while the transmitter is idle. A 3-bit limit input names the table slot used for full power. A table index walks between slot 0 and that limit. It gives a smooth power rise when a transmission starts and a smooth fall when it ends, and it can shape amplitude-keyed symbols the same way. In on-off keying, the data bit picks slot 1 or slot 0 directly.

The index moves only on sub-symbol ticks. Each symbol-rate strobe starts a burst of eight ticks, spaced a fixed number of clocks apart by an internal divider that the strobe reloads. After the transmit enable falls, the index runs down to zero. The transmitter then goes idle and raises a one-cycle completion pulse. A sleep request wipes every table slot except slot 0.

Top module: `pa_ramp_shaper`

## Requirements
- R1: After reset every table slot holds 0, the index is 0, `pa_level` is 0 and `ramp_done` is low.
- R2: While idle and not sleeping, a write with `tbl_wr_en` high stores `tbl_wr_data` into slot `tbl_wr_addr` at the clock edge. In modes 0, 1 and 3, `pa_level` shows the slot selected by the current index (slot 0 when idle).
- R3: A table write is ignored while a transmission is active, from the edge that starts it until the edge that ends it.
- R4: While `sleep_req` is high, slots 1 to 7 are cleared at each edge and slot 0 keeps its value. A write attempted in the same cycle is ignored.
- R5: A `sym_stb` pulse yields a tick in its own cycle, then one tick every TICK_DIV (default 2) clocks, for SUB_STEPS (default 8) ticks in total. The index changes only on a tick.
- R6: In ramp mode (`mode_sel` 0 or 3), while `tx_en` is high, each tick raises the index by one, saturating at `max_idx`. An index above `max_idx` drops to `max_idx` on the next tick.
- R7: After `tx_en` falls, each tick lowers the index by one, saturating at 0. One clock after the index is 0 with `tx_en` low, the block goes idle and `ramp_done` is high for exactly one cycle.
- R8: In amplitude-shaping mode (`mode_sel` 1), while `tx_en` is high, a tick moves the index toward `max_idx` when `tx_bit` is 1 and toward 0 when `tx_bit` is 0, with the same saturation.
- R9: In on-off keying mode (`mode_sel` 2), while active, `pa_level` is slot 1 when `tx_bit` is 1 and slot 0 when it is 0, following `tx_bit` in the same cycle. The index stays 0, and `ramp_done` pulses one clock after `tx_en` falls.
- R10: When idle and `tx_en` is high at an edge, the block becomes active at that edge with index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 3 | Table slot to write |
| tbl_wr_data | input | 8 | Power code to store |
| max_idx | input | 3 | Full-power slot, upper bound of the index |
| mode_sel | input | 2 | 0/3 ramp, 1 amplitude shaping, 2 on-off keying |
| tx_en | input | 1 | Transmit request |
| sym_stb | input | 1 | One-cycle symbol-rate strobe |
| tx_bit | input | 1 | Current data bit |
| sleep_req | input | 1 | Sleep request, clears slots 1 to 7 |
| pa_level | output | 8 | Selected power code |
| ramp_done | output | 1 | One-cycle pulse when a transmission has fully wound down |

## Verification
The table is filled with codes that carry their own slot number, so every output sample tells which slot the index points at. The ramp is tried with a limit of 5, which shows saturation at the top and the bottom. Amplitude shaping is tried with a run of ones, a run of zeros, and a limit lowered below the current index in mid-symbol, which shows the jump down to the new limit. On-off keying is tried with alternating bits, which shows that the output follows the bit with no tick. Writes during an active transmission and a sleep pulse combined with a write are tried last, and each is read back through later transmissions.

// File: rtl/pa_pkg.sv
package pa_pkg;
    typedef enum logic [1:0] {
        PA_RAMP     = 2'd0,
        PA_ASK      = 2'd1,
        PA_OOK      = 2'd2,
        PA_RAMP_ALT = 2'd3
    } pa_mode_e;
endpackage

// File: rtl/pa_subtick.sv
module pa_subtick #(
    parameter int SUB_STEPS = 8,
    parameter int TICK_DIV  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_stb,
    output logic tick
);
    localparam int STEP_W = $clog2(SUB_STEPS) + 1;
    localparam int DIV_W  = $clog2(TICK_DIV) + 1;

    typedef struct packed {
        logic [STEP_W-1:0] left;
        logic [DIV_W-1:0]  div;
    } sub_st_t;

    sub_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = sym_stb || (st_q.left != '0 && st_q.div == '0);
        if (sym_stb) begin
            st_d.left = STEP_W'(SUB_STEPS - 1);
            st_d.div  = DIV_W'(TICK_DIV - 1);
        end else if (st_q.left != '0) begin
            if (st_q.div == '0) begin
                st_d.left = st_q.left - STEP_W'(1);
                st_d.div  = DIV_W'(TICK_DIV - 1);
            end else begin
                st_d.div = st_q.div - DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pa_power_table.sv
module pa_power_table #(
    parameter int  ENTRIES = 8,
    parameter int  PWR_W   = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_addr,
    input  logic [PWR_W-1:0]                wr_data,
    input  logic                            lock,
    input  logic                            sleep_req,
    output logic [ENTRIES-1:0][PWR_W-1:0]   tbl
);
    logic [ENTRIES-1:0][PWR_W-1:0] tbl_d, tbl_q;
    logic wr_ok;

    always_comb begin
        wr_ok = wr_en && !lock && !sleep_req;
        tbl_d = tbl_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (sleep_req && i != 0) begin
                tbl_d[i] = '0;
            end else if (wr_ok && wr_addr == IDX_W'(i)) begin
                tbl_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign tbl = tbl_q;
endmodule

// File: rtl/pa_index_ctrl.sv
module pa_index_ctrl
    import pa_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             tx_en,
    input  pa_mode_e         mode,
    input  logic             sym_bit,
    input  logic [IDX_W-1:0] max_idx,
    output logic [IDX_W-1:0] idx,
    output logic             active,
    output logic             done
);
    typedef struct packed {
        logic             active;
        logic             done;
        logic [IDX_W-1:0] idx;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic [IDX_W-1:0] step_up, step_dn;
    logic             go_up;

    always_comb begin
        step_up = (st_q.idx >= max_idx) ? max_idx : st_q.idx + IDX_W'(1);
        step_dn = (st_q.idx == '0) ? '0 : st_q.idx - IDX_W'(1);
        go_up   = tx_en && (mode != PA_ASK || sym_bit);

        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.active) begin
            st_d.idx = '0;
            if (tx_en) st_d.active = 1'b1;
        end else if (!tx_en && st_q.idx == '0) begin
            st_d.active = 1'b0;
            st_d.done   = 1'b1;
        end else if (tick && mode != PA_OOK) begin
            st_d.idx = go_up ? step_up : step_dn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx    = st_q.idx;
    assign active = st_q.active;
    assign done   = st_q.done;
endmodule

// File: rtl/pa_ramp_shaper.sv
module pa_ramp_shaper
    import pa_pkg::*;
#(
    parameter int  ENTRIES   = 8,
    parameter int  PWR_W     = 8,
    parameter int  SUB_STEPS = 8,
    parameter int  TICK_DIV  = 2,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_wr_en,
    input  logic [IDX_W-1:0] tbl_wr_addr,
    input  logic [PWR_W-1:0] tbl_wr_data,
    input  logic [IDX_W-1:0] max_idx,
    input  logic [1:0]       mode_sel,
    input  logic             tx_en,
    input  logic             sym_stb,
    input  logic             tx_bit,
    input  logic             sleep_req,
    output logic [PWR_W-1:0] pa_level,
    output logic             ramp_done
);
    pa_mode_e                      mode;
    logic                          sub_tick;
    logic                          tx_active;
    logic [IDX_W-1:0]              cur_idx;
    logic [ENTRIES-1:0][PWR_W-1:0] tbl_w;

    assign mode = pa_mode_e'(mode_sel);

    pa_subtick #(
        .SUB_STEPS(SUB_STEPS),
        .TICK_DIV (TICK_DIV)
    ) i_subtick (
        .clk    (clk),
        .rst_n  (rst_n),
        .sym_stb(sym_stb),
        .tick   (sub_tick)
    );

    pa_power_table #(
        .ENTRIES(ENTRIES),
        .PWR_W  (PWR_W)
    ) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_addr  (tbl_wr_addr),
        .wr_data  (tbl_wr_data),
        .lock     (tx_active),
        .sleep_req(sleep_req),
        .tbl      (tbl_w)
    );

    pa_index_ctrl #(
        .IDX_W(IDX_W)
    ) i_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sub_tick),
        .tx_en  (tx_en),
        .mode   (mode),
        .sym_bit(tx_bit),
        .max_idx(max_idx),
        .idx    (cur_idx),
        .active (tx_active),
        .done   (ramp_done)
    );

    always_comb begin
        if (mode == PA_OOK) begin
            pa_level = (tx_active && tx_bit) ? tbl_w[1] : tbl_w[0];
        end else begin
            pa_level = tbl_w[cur_idx];
        end
    end
endmodule

// File: rtl/pa_ramp_shaper_chk.sv
module pa_ramp_shaper_chk
    import pa_pkg::*;
#(
    parameter int  ENTRIES = 8,
    parameter int  PWR_W   = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tick,
    input logic                          tx_en,
    input pa_mode_e                      mode,
    input logic [IDX_W-1:0]              max_idx,
    input logic [IDX_W-1:0]              idx,
    input logic                          active,
    input logic                          done,
    input logic                          wr_en,
    input logic [IDX_W-1:0]              wr_addr,
    input logic                          sleep_req,
    input logic [ENTRIES-1:0][PWR_W-1:0] tbl
);
    logic upper_clear;

    always_comb begin
        upper_clear = 1'b1;
        for (int i = 1; i < ENTRIES; i++) begin
            if (tbl[i] != '0) upper_clear = 1'b0;
        end
    end

    // R5
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(idx));

    // R10
    idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> idx == '0);

    // R6
    up_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tx_en && tick && (mode == PA_RAMP || mode == PA_RAMP_ALT))
        |=> idx <= $past(max_idx));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!active && idx == '0));

    // R3
    wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr_en) |=> tbl[$past(wr_addr)] == $past(tbl[wr_addr]));

    // R4
    sleep_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> upper_clear);

    // R9
    ook_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == PA_OOK |=> $stable(idx));
endmodule

bind pa_ramp_shaper pa_ramp_shaper_chk #(
    .ENTRIES(ENTRIES),
    .PWR_W  (PWR_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sub_tick),
    .tx_en    (tx_en),
    .mode     (mode),
    .max_idx  (max_idx),
    .idx      (cur_idx),
    .active   (tx_active),
    .done     (ramp_done),
    .wr_en    (tbl_wr_en),
    .wr_addr  (tbl_wr_addr),
    .sleep_req(sleep_req),
    .tbl      (tbl_w)
);

// File: tb/test_pa_ramp_shaper.sv
`timescale 1ns/1ps
module test_pa_ramp_shaper;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tbl_wr_en;
    logic [2:0] tbl_wr_addr;
    logic [7:0] tbl_wr_data;
    logic [2:0] max_idx;
    logic [1:0] mode_sel;
    logic       tx_en;
    logic       sym_stb;
    logic       tx_bit;
    logic       sleep_req;
    logic [7:0] pa_level;
    logic       ramp_done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pa_ramp_shaper i_pa_ramp_shaper (
        .clk        (clk),
        .rst_n      (rst_n),
        .tbl_wr_en  (tbl_wr_en),
        .tbl_wr_addr(tbl_wr_addr),
        .tbl_wr_data(tbl_wr_data),
        .max_idx    (max_idx),
        .mode_sel   (mode_sel),
        .tx_en      (tx_en),
        .sym_stb    (sym_stb),
        .tx_bit     (tx_bit),
        .sleep_req  (sleep_req),
        .pa_level   (pa_level),
        .ramp_done  (ramp_done)
    );

    // Fields: mode[12:11] tx_en[10] stb[9] bit[8] max[7:5] exp_slot[4:2] exp_done[1] wait2[0]
    localparam int NV = 51;
    localparam logic [12:0] VEC [NV] = '{
        13'b00_1_0_0_101_000_0_0, 13'b00_1_1_0_101_001_0_0, 13'b00_1_0_0_101_010_0_1,
        13'b00_1_0_0_101_011_0_1, 13'b00_1_0_0_101_100_0_1, 13'b00_1_0_0_101_101_0_1,
        13'b00_1_0_0_101_101_0_1, 13'b00_1_0_0_101_101_0_1, 13'b00_1_0_0_101_101_0_1,
        13'b00_0_0_0_101_101_0_0, 13'b00_0_1_0_101_100_0_0, 13'b00_0_0_0_101_011_0_1,
        13'b00_0_0_0_101_010_0_1, 13'b00_0_0_0_101_001_0_1, 13'b00_0_0_0_101_000_0_1,
        13'b00_0_0_0_101_000_1_0, 13'b00_0_0_0_101_000_0_0,
        13'b01_1_0_1_111_000_0_0, 13'b01_1_1_1_111_001_0_0, 13'b01_1_0_1_111_010_0_1,
        13'b01_1_0_1_111_011_0_1, 13'b01_1_0_1_111_100_0_1, 13'b01_1_0_1_111_101_0_1,
        13'b01_1_0_1_111_110_0_1, 13'b01_1_0_1_111_111_0_1, 13'b01_1_0_1_111_111_0_1,
        13'b01_1_1_0_111_110_0_0, 13'b01_1_0_0_111_101_0_1, 13'b01_1_0_0_111_100_0_1,
        13'b01_1_0_0_111_011_0_1, 13'b01_1_0_0_111_010_0_1, 13'b01_1_0_0_111_001_0_1,
        13'b01_1_0_0_111_000_0_1, 13'b01_1_0_0_111_000_0_1,
        13'b01_1_1_1_011_001_0_0, 13'b01_1_0_1_011_010_0_1, 13'b01_1_0_1_011_011_0_1,
        13'b01_1_0_1_011_011_0_1, 13'b01_1_0_1_001_001_0_1, 13'b01_1_0_1_001_001_0_1,
        13'b01_1_0_0_001_000_0_1, 13'b01_1_0_0_001_000_0_1,
        13'b01_0_0_0_001_000_1_0, 13'b01_0_0_0_001_000_0_0,
        13'b10_1_0_0_001_000_0_0, 13'b10_1_0_1_001_001_0_0, 13'b10_1_0_0_001_000_0_0,
        13'b10_1_1_1_001_001_0_0, 13'b10_1_0_1_001_001_0_1, 13'b10_0_0_1_001_000_1_0,
        13'b10_0_0_1_001_000_0_0
    };

    function automatic logic [7:0] lvl(input int slot);
        return {3'(slot), 5'b01010};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        tbl_wr_en = 1'b1; tbl_wr_addr = a; tbl_wr_data = d;
        cyc(1);
        tbl_wr_en = 1'b0;
    endtask

    task automatic strobe_and_wait(input int extra);
        sym_stb = 1'b1;
        @(posedge clk); @(negedge clk);
        sym_stb = 1'b0;
        cyc(extra);
    endtask

    logic [12:0] cur;
    string       tag;

    initial begin
        rst_n = 1'b0; tbl_wr_en = 1'b0; tbl_wr_addr = '0; tbl_wr_data = '0;
        max_idx = '0; mode_sel = 2'd0; tx_en = 1'b0; sym_stb = 1'b0;
        tx_bit = 1'b0; sleep_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        chk("R1 level", pa_level, 8'h00);
        chk("R1 done", {7'b0, ramp_done}, 8'h00);

        for (int s = 0; s < 8; s++) wr(3'(s), lvl(s));
        // R2: idle output shows slot 0
        chk("R2 idle", pa_level, lvl(0));

        for (int v = 0; v < NV; v++) begin
            cur = VEC[v];
            mode_sel = cur[12:11]; tx_en = cur[10]; sym_stb = cur[9];
            tx_bit = cur[8]; max_idx = cur[7:5];
            @(posedge clk); @(negedge clk);
            sym_stb = 1'b0;
            if (cur[0]) cyc(1);
            if (cur[12:11] == 2'd2)      tag = "R9";
            else if (cur[12:11] == 2'd1) tag = "R8";
            else if (cur[9])             tag = "R5";
            else if (cur[10])            tag = "R6";
            else                         tag = "R7";
            chk($sformatf("%s vec%0d level", tag, v), pa_level, lvl(int'(cur[4:2])));
            chk($sformatf("R7 vec%0d done", v), {7'b0, ramp_done}, {7'b0, cur[1]});
        end

        cyc(20);
        // R10: activation keeps index at 0
        mode_sel = 2'd0; max_idx = 3'd7; tx_en = 1'b1;
        cyc(1);
        chk("R10 start", pa_level, lvl(0));
        strobe_and_wait(15);
        chk("R6 full", pa_level, lvl(7));
        // R3: write while active is ignored
        wr(3'd7, 8'h55);
        chk("R3 locked", pa_level, lvl(7));
        tx_en = 1'b0;
        strobe_and_wait(15);
        chk("R7 down", pa_level, lvl(0));
        chk("R7 done gone", {7'b0, ramp_done}, 8'h00);
        // R2: idle write accepted
        wr(3'd0, 8'h3C);
        chk("R2 slot0", pa_level, 8'h3C);
        // R4: sleep clears upper slots, keeps slot 0, blocks write
        sleep_req = 1'b1; tbl_wr_en = 1'b1; tbl_wr_addr = 3'd0; tbl_wr_data = 8'h99;
        cyc(1);
        sleep_req = 1'b0; tbl_wr_en = 1'b0;
        chk("R4 slot0 kept", pa_level, 8'h3C);
        mode_sel = 2'd2; tx_en = 1'b1; tx_bit = 1'b1;
        cyc(1);
        chk("R4 slot1 cleared", pa_level, 8'h00);
        tx_bit = 1'b0;
        cyc(1);
        chk("R9 bit0", pa_level, 8'h3C);
        tx_en = 1'b0;
        cyc(1);
        chk("R9 done", {7'b0, ramp_done}, 8'h01);
        cyc(20);
        mode_sel = 2'd3; max_idx = 3'd7; tx_en = 1'b1;
        cyc(1);
        strobe_and_wait(15);
        chk("R4 slot7 cleared", pa_level, 8'h00);
        tx_en = 1'b0;
        strobe_and_wait(16);
        chk("R7 final idle", pa_level, 8'h3C);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule